// File: doc/BRIEF.md
# Edge-Interrupt GPIO Register Block

This block is a byte-addressed register file in front of a bank of general-purpose pins. It has 24 pins by default, in three 8-bit banks. Software sets the direction of each pin and drives output levels through two registers: one sets bits and one clears them. It reads back the synchronised pin levels and chooses, for each pin, whether a rising edge, a falling edge or both should be recorded.

An enabled edge sets two sticky bits for the pin: an interrupt-pending bit and an edge-seen bit. Software clears each one by writing a 1 to it. A single active-high interrupt line stays asserted while any pending bit has its interrupt enable set. The block has no level-triggered mode.

Top module: `edge_gpio_regs`

## Requirements
- R1: After reset every register reads 0 (all status and enable bits clear), `pin_oe` and `pin_out` are all zero, and `irq` is low.
- R2: Writing a byte to the set group drives high every output latch bit written as 1 in the addressed bank; bits written as 0 keep their value. The set and clear groups both read back the output latch.
- R3: Writing a byte to the clear group drives low every output latch bit written as 1 in the addressed bank; bits written as 0 keep their value.
- R4: In the direction group, bit value 1 makes the pin an output (`pin_oe` high) and 0 makes it an input. `pin_oe` and `pin_out` change only one cycle after a write.
- R5: The monitor group returns each pin level after a two-flop synchroniser. A pin change made just before a clock edge is not yet visible to a read sampled at the following clock edge.
- R6: Each pin has a rising-edge enable and a falling-edge enable; setting both senses either edge. An edge whose polarity is not enabled leaves both status groups unchanged.
- R7: An enabled edge sets the pin's bit in both the interrupt-status group and the edge-status group. This happens at the third clock edge after the pin changes. The bits hold until cleared.
- R8: `irq` is high exactly when some interrupt-status bit has its interrupt-enable bit set. Clearing the enable drops `irq` while the status bit stays pending.
- R9: Writing 1 to a bit of the interrupt-status or edge-status group clears that bit. Bits written as 0 are unaffected. The two groups are cleared independently.
- R10: If an enabled edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R11: Group g sits at addresses 4·g to 4·g+2. Offset 0 holds the most significant bank (pins 23..16), offset 1 holds pins 15..8 and offset 2 holds pins 7..0. Pin n uses bit n mod 8. The groups are: 0 monitor, 1 set, 2 clear, 3 direction, 4 rise enable, 5 fall enable, 6 interrupt enable, 7 interrupt status, 8 edge status. Offset 3 and groups above 8 read 0, and writes to them are ignored.
- R12: `rdata` loads the addressed byte at a clock edge where `rd_en` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (6) | Register byte address |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| rdata | output | 8 | Registered read data |
| pin_in | input | NBANKS*8 (24) | Pin levels, asynchronous |
| pin_out | output | NBANKS*8 (24) | Output drive values |
| pin_oe | output | NBANKS*8 (24) | Output enables |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is an edge and a write-one-to-clear arriving at one status bit in the same clock cycle, because the edge only becomes visible three register stages after the pin moves.

The stimulus first leaves a status bit pending with both polarities enabled. It then moves the pin at a falling clock edge, waits two rising edges and starts the clearing write so that the write lands on the exact edge where the second detection is recorded. A control write one edge later, with no new edge, shows that the same clear does remove the bit.

// File: rtl/egp_pkg.sv
`timescale 1ns/1ps
package egp_pkg;
  localparam int GRP_STRIDE = 4;
  localparam int BANK_W     = 8;

  typedef enum logic [3:0] {
    GRP_MON = 4'd0,
    GRP_SET = 4'd1,
    GRP_CLR = 4'd2,
    GRP_DIR = 4'd3,
    GRP_REN = 4'd4,
    GRP_FEN = 4'd5,
    GRP_IEN = 4'd6,
    GRP_IST = 4'd7,
    GRP_EST = 4'd8
  } grp_e;
endpackage

// File: rtl/egp_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser per pin plus a one-cycle history for edge detection.
module egp_sync #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  always_comb begin
    level_o = sync_q;
    rise_o  = sync_q & ~hist_q;
    fall_o  = ~sync_q & hist_q;
  end
endmodule

// File: rtl/egp_bank_reg.sv
`timescale 1ns/1ps
// Plain read/write register built from byte banks, each with its own write enable.
module egp_bank_reg #(
  parameter int NBANKS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NBANKS-1:0]     we_i,
  input  logic [7:0]            wbyte_i,
  output logic [NBANKS*8-1:0]   q_o
);
  logic [NBANKS*8-1:0] q_d, q_q;

  always_comb begin
    q_d = q_q;
    for (int b = 0; b < NBANKS; b++) begin
      if (we_i[b]) q_d[b*8 +: 8] = wbyte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/egp_w1c_status.sv
`timescale 1ns/1ps
// Sticky status bits: set by events, cleared by write-one; a set beats a clear.
module egp_w1c_status #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_d, stat_q;

  always_comb stat_d = (stat_q & ~clr_i) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/edge_gpio_regs.sv
`timescale 1ns/1ps
module edge_gpio_regs
  import egp_pkg::*;
#(
  parameter int NBANKS = 3,
  parameter int ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           wdata,
  input  logic                 wr_en,
  input  logic                 rd_en,
  output logic [7:0]           rdata,
  input  logic [NBANKS*8-1:0]  pin_in,
  output logic [NBANKS*8-1:0]  pin_out,
  output logic [NBANKS*8-1:0]  pin_oe,
  output logic                 irq
);
  localparam int NPINS  = NBANKS * BANK_W;
  localparam int SLOT_W = $clog2(GRP_STRIDE);
  localparam int GRP_W  = ADDR_W - SLOT_W;

  // ---------------- address decode ----------------
  logic [GRP_W-1:0]  grp;
  logic [SLOT_W-1:0] slot;
  logic [NBANKS-1:0] bank_sel;
  logic [NPINS-1:0]  wspread;

  always_comb begin
    grp  = addr[ADDR_W-1:SLOT_W];
    slot = addr[SLOT_W-1:0];
    for (int b = 0; b < NBANKS; b++) begin
      bank_sel[b] = (int'(slot) == (NBANKS - 1 - b));
    end
  end

  genvar gb;
  generate
    for (gb = 0; gb < NBANKS; gb++) begin : g_spread
      assign wspread[gb*8 +: 8] = bank_sel[gb] ? wdata : 8'h00;
    end
  endgenerate

  logic wr_set, wr_clr, wr_dir, wr_ren, wr_fen, wr_ien, wr_ist, wr_est;
  always_comb begin
    wr_set = wr_en && (grp == GRP_W'(GRP_SET));
    wr_clr = wr_en && (grp == GRP_W'(GRP_CLR));
    wr_dir = wr_en && (grp == GRP_W'(GRP_DIR));
    wr_ren = wr_en && (grp == GRP_W'(GRP_REN));
    wr_fen = wr_en && (grp == GRP_W'(GRP_FEN));
    wr_ien = wr_en && (grp == GRP_W'(GRP_IEN));
    wr_ist = wr_en && (grp == GRP_W'(GRP_IST));
    wr_est = wr_en && (grp == GRP_W'(GRP_EST));
  end

  // ---------------- configuration registers ----------------
  logic [NPINS-1:0] dir_q, ren_q, fen_q, ien_q;

  egp_bank_reg #(.NBANKS(NBANKS)) u_dir (
    .clk(clk), .rst_n(rst_n), .we_i(wr_dir ? bank_sel : '0), .wbyte_i(wdata), .q_o(dir_q));
  egp_bank_reg #(.NBANKS(NBANKS)) u_ren (
    .clk(clk), .rst_n(rst_n), .we_i(wr_ren ? bank_sel : '0), .wbyte_i(wdata), .q_o(ren_q));
  egp_bank_reg #(.NBANKS(NBANKS)) u_fen (
    .clk(clk), .rst_n(rst_n), .we_i(wr_fen ? bank_sel : '0), .wbyte_i(wdata), .q_o(fen_q));
  egp_bank_reg #(.NBANKS(NBANKS)) u_ien (
    .clk(clk), .rst_n(rst_n), .we_i(wr_ien ? bank_sel : '0), .wbyte_i(wdata), .q_o(ien_q));

  // ---------------- output latch (write-one set / write-one clear) ----------------
  logic [NPINS-1:0] out_d, out_q;

  always_comb begin
    out_d = out_q;
    if (wr_set) out_d = out_d | wspread;
    if (wr_clr) out_d = out_d & ~wspread;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  // ---------------- input sampling and edge capture ----------------
  logic [NPINS-1:0] level, rise, fall, edge_ev;

  egp_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_in),
    .level_o(level), .rise_o(rise), .fall_o(fall));

  always_comb edge_ev = (rise & ren_q) | (fall & fen_q);

  logic [NPINS-1:0] ist_q, est_q;

  egp_w1c_status #(.W(NPINS)) u_ist (
    .clk(clk), .rst_n(rst_n), .set_i(edge_ev),
    .clr_i(wr_ist ? wspread : '0), .stat_o(ist_q));
  egp_w1c_status #(.W(NPINS)) u_est (
    .clk(clk), .rst_n(rst_n), .set_i(edge_ev),
    .clr_i(wr_est ? wspread : '0), .stat_o(est_q));

  // ---------------- read path ----------------
  logic [NPINS-1:0] rd_src;
  logic [7:0]       rd_byte, rdata_d, rdata_q;

  always_comb begin
    case (grp)
      GRP_W'(GRP_MON): rd_src = level;
      GRP_W'(GRP_SET): rd_src = out_q;
      GRP_W'(GRP_CLR): rd_src = out_q;
      GRP_W'(GRP_DIR): rd_src = dir_q;
      GRP_W'(GRP_REN): rd_src = ren_q;
      GRP_W'(GRP_FEN): rd_src = fen_q;
      GRP_W'(GRP_IEN): rd_src = ien_q;
      GRP_W'(GRP_IST): rd_src = ist_q;
      GRP_W'(GRP_EST): rd_src = est_q;
      default:         rd_src = '0;
    endcase
    rd_byte = 8'h00;
    for (int b = 0; b < NBANKS; b++) begin
      if (bank_sel[b]) rd_byte = rd_byte | rd_src[b*8 +: 8];
    end
    rdata_d = rd_en ? rd_byte : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  // ---------------- outputs ----------------
  assign rdata   = rdata_q;
  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(ist_q & ien_q);
endmodule

// File: rtl/egp_checker.sv
`timescale 1ns/1ps
module egp_checker #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         irq,
  input logic [W-1:0] ien,
  input logic [W-1:0] ist,
  input logic [W-1:0] est,
  input logic [W-1:0] ev,
  input logic [W-1:0] oe,
  input logic [W-1:0] out
);
  p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);

  p_irq_drop_by_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en));

  p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(ist) & ~ist) || |($past(est) & ~est)) |-> $past(wr_en));

  p_edge_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> (((ist & $past(ev)) == $past(ev)) && ((est & $past(ev)) == $past(ev))));

  p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ev) && wr_en) |=> ((ist & $past(ev)) == $past(ev)));

  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ist & ~$past(ist))) |-> $past(|ev));

  p_dir_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe) |-> $past(wr_en));

  p_out_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out) |-> $past(wr_en));
endmodule

bind edge_gpio_regs egp_checker #(.W(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .irq(irq),
  .ien(ien_q), .ist(ist_q), .est(est_q), .ev(edge_ev),
  .oe(pin_oe), .out(pin_out));

// File: tb/edge_gpio_regs_test.sv
`timescale 1ns/1ps
module edge_gpio_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rdata;
  logic [23:0] pins = '0;
  logic [23:0] pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  edge_gpio_regs uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .pin_in(pins), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq));

  // Group g, bank b (0 = pins 7..0) per R11
  function automatic logic [5:0] ra(input int g, input int b);
    return 6'(g * 4 + (2 - b));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rd24(input int g, output logic [23:0] v);
    logic [7:0] b0, b1, b2;
    rd(ra(g, 2), b2); rd(ra(g, 1), b1); rd(ra(g, 0), b0);
    v = {b2, b1, b0};
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [23:0] v;
    for (int g = 0; g < 9; g++) begin
      rd24(g, v);
      check($sformatf("R1 group %0d", g), v, 24'h0);
    end
    check("R1 pin_oe", pin_oe, 24'h0);
    check("R1 pin_out", pin_out, 24'h0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_outputs();
    logic [7:0] d;
    wr(ra(3, 2), 8'hFF);
    check("R4 dir bank2", pin_oe, 24'hFF0000);
    wr(ra(1, 0), 8'hA5);
    check("R2 set bank0", pin_out, 24'h0000A5);
    wr(ra(1, 1), 8'h0F);
    check("R2 set keeps others", pin_out, 24'h000FA5);
    wr(ra(2, 0), 8'h05);
    check("R3 clear bank0", pin_out, 24'h000FA0);
    rd(ra(2, 1), d);
    check("R2 readback via clear group", d, 8'h0F);
    wr(6'(1 * 4 + 3), 8'hFF);
    check("R11 offset3 write ignored", pin_out, 24'h000FA0);
    rd(6'(1 * 4 + 3), d);
    check("R11 offset3 reads 0", d, 8'h00);
    wr(6'(12 * 4), 8'hFF);
    rd(6'(12 * 4), d);
    check("R11 unmapped group reads 0", d, 8'h00);
    wr(ra(2, 1), 8'hFF); wr(ra(2, 0), 8'hFF); wr(ra(3, 2), 8'h00);
    check("R3 clear all", pin_out, 24'h0);
    check("R4 dir back to input", pin_oe, 24'h0);
  endtask

  task automatic t_monitor();
    logic [7:0] d;
    @(negedge clk); pins = 24'h123456;
    rd(ra(0, 0), d);
    check("R5 old level before sync", d, 8'h00);
    settle();
    rd(ra(0, 2), d);
    check("R5 monitor bank2", d, 8'h12);
    rd(ra(0, 0), d);
    check("R5 monitor bank0", d, 8'h56);
    @(negedge clk); addr = ra(0, 1);
    repeat (2) @(negedge clk);
    check("R12 rdata holds without rd_en", rdata, 8'h56);
    @(negedge clk); pins = 24'h0;
    settle();
  endtask

  task automatic t_edges();
    logic [23:0] v;
    wr(ra(4, 0), 8'h01);        // rise pin0
    wr(ra(5, 1), 8'h02);        // fall pin9
    wr(ra(4, 2), 8'h02);        // rise pin17
    wr(ra(5, 2), 8'h02);        // fall pin17
    @(negedge clk); pins[0] = 1'b1; pins[9] = 1'b1; pins[5] = 1'b1;
    settle();
    rd24(7, v);
    check("R7 rise sets pin0 only", v, 24'h000001);
    @(negedge clk); pins[0] = 1'b0; pins[9] = 1'b0; pins[5] = 1'b0;
    settle();
    rd24(7, v);
    check("R6 fall pin9, none pin0/pin5", v, 24'h000201);
    @(negedge clk); pins[17] = 1'b1;
    settle();
    rd24(8, v);
    check("R6 both-edge pin17 rise", v, 24'h020201);
    wr(ra(8, 2), 8'h02);
    @(negedge clk); pins[17] = 1'b0;
    settle();
    rd24(8, v);
    check("R6 both-edge pin17 fall", v, 24'h020201);
    check("R8 irq low with no enables", irq, 0);
  endtask

  task automatic t_irq();
    logic [23:0] v;
    wr(ra(6, 0), 8'h01);
    check("R8 irq on enable", irq, 1);
    wr(ra(7, 0), 8'h01);
    check("R8 irq after clear", irq, 0);
    rd24(7, v);
    check("R9 only pin0 cleared", v, 24'h020200);
    rd24(8, v);
    check("R9 edge status independent", v, 24'h020201);
    wr(ra(6, 1), 8'h02);
    check("R8 irq from pin9", irq, 1);
    wr(ra(6, 1), 8'h00);
    check("R8 irq drops on disable", irq, 0);
    rd24(7, v);
    check("R8 status stays pending", v, 24'h020200);
    wr(ra(7, 2), 8'hFF); wr(ra(7, 1), 8'hFF); wr(ra(7, 0), 8'hFF);
    wr(ra(8, 2), 8'hFF); wr(ra(8, 1), 8'hFF); wr(ra(8, 0), 8'hFF);
    rd24(7, v);
    check("R9 all cleared", v, 24'h0);
  endtask

  task automatic t_edge_wins();
    logic [7:0] d;
    wr(ra(5, 0), 8'h01);        // pin0 now both edges
    @(negedge clk); pins[0] = 1'b1;
    settle();
    rd(ra(7, 0), d);
    check("R7 pending before collision", d, 8'h01);
    @(negedge clk); pins[0] = 1'b0;
    @(posedge clk); @(posedge clk);
    wr(ra(7, 0), 8'h01);        // sampled on the edge the fall is recorded
    rd(ra(7, 0), d);
    check("R10 edge wins over clear", d, 8'h01);
    wr(ra(7, 0), 8'h01);
    rd(ra(7, 0), d);
    check("R9 plain clear", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_outputs();
    t_monitor();
    t_edges();
    t_irq();
    t_edge_wins();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule